// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the purely combinational datapath of a small 8-bit RISC core. It accepts two 8-bit operands (the decoder has already chosen register or immediate for the second one), the current carry and zero bits of the status register, and a 4-bit operation code. In the same cycle it returns the 8-bit result, a candidate status vector, and a write-enable mask. The core merges the vector into its status register only where the mask is set, so each class of operation changes exactly its own subset of flags.

All arithmetic, including negate, increment and decrement, runs through a single parameterised ripple add/subtract chain. Subtraction is performed as the addition of the inverted second operand. The flag stage turns the raw carries of that chain into borrow, half-carry and overflow. There is no clock and no state. The house state-register pattern does not apply here, so the block holds only combinational processes.

Top module: `alu8`

## Requirements
- R1: Operation codes 0 (add), 1 (add with carry_in), 2 (subtract) and 3 (subtract with carry_in as borrow) produce the low 8 bits of a+b, a+b+cin, a-b and a-b-cin respectively.
- R2: Codes 0 to 3 set flag_we to 0x3F. C is the carry out of bit 7 for additions and the borrow for subtractions. H is the carry or borrow out of bit 3. V is the two's-complement overflow. N is result bit 7. Z is set when the result is zero, except as R3 states for code 3.
- R3: For code 3, Z is set only when the result is zero and zero_in is 1.
- R4: Codes 4 (AND), 5 (OR) and 6 (XOR) produce the bitwise result, set flag_we to 0x1E and always report V=0.
- R5: Code 7 produces 0xFF minus opnd_a, sets flag_we to 0x1F (H not written) and reports C=1 and V=0.
- R6: Code 8 produces 0x00 minus opnd_a and sets flag_we to 0x3F. C is 1 when the result is non-zero, V is 1 when the result is 0x80, and H is the borrow out of bit 3.
- R7: Codes 9 (opnd_a+1) and 10 (opnd_a-1) set flag_we to 0x1E, so C is never written. V is 1 for increment when opnd_a is 0x7F, and for decrement when opnd_a is 0x80.
- R8: Whenever S is written, it equals N XOR V.
- R9: flags_out uses bits H=5, S=4, V=3, N=2, Z=1, C=0. Bits 7 and 6 are always 0, and every bit whose flag_we bit is 0 reads 0.
- R10: Codes 11 to 15 pass opnd_a to the result and set flag_we and flags_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 8 | First operand (destination register value) |
| opnd_b | input | 8 | Second operand (register or immediate) |
| carry_in | input | 1 | Current C flag |
| zero_in | input | 1 | Current Z flag, used by subtract with carry |
| op_sel | input | 4 | Operation code, see R1 to R10 |
| result | output | 8 | Operation result |
| flags_out | output | 8 | Candidate status vector, layout per R9 |
| flag_we | output | 8 | Per-flag write mask, same layout |

## Verification
Immediate assertions run whenever the inputs change and check the rules that hold for every operand. These rules are: the sign rule, V cleared for logic operations, C forced for one's complement, sticky Z for subtract with carry, no write for unused codes, and flags reading zero outside the mask. The exact numeric values of result, carry, half-carry and overflow can only be shown by the bench's scenarios. Those scenarios cover directed boundary operands such as 0x7F, 0x80 and nibble borrows, and a long random sweep of operands, carry and zero inputs that is compared against an independent integer model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_COM = 4'd7,
        OP_NEG = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10
    } alu_op_e;

    localparam int FB_C = 0;
    localparam int FB_Z = 1;
    localparam int FB_N = 2;
    localparam int FB_V = 3;
    localparam int FB_S = 4;
    localparam int FB_H = 5;

    localparam logic [7:0] MASK_ARITH = 8'h3F;
    localparam logic [7:0] MASK_LOGIC = 8'h1E;
    localparam logic [7:0] MASK_COM   = 8'h1F;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8,
    parameter int HALF  = 4
) (
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] y_in,
    input  logic             invert_y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             c_out,
    output logic             c_half,
    output logic             c_into_msb
);
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] y_eff;

    assign carry[0] = cin;
    assign y_eff    = invert_y ? ~y_in : y_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = x_in[i] ^ y_eff[i] ^ carry[i];
        assign carry[i+1] = (x_in[i] & y_eff[i]) | (carry[i] & (x_in[i] ^ y_eff[i]));
    end

    assign c_out      = carry[WIDTH];
    assign c_half     = carry[HALF];
    assign c_into_msb = carry[WIDTH-1];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] r
);
    always_comb begin
        unique case (op)
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            OP_XOR:  r = a ^ b;
            OP_COM:  r = ~a;
            default: r = a;
        endcase
    end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] res,
    input  logic             c_out,
    input  logic             c_half,
    input  logic             c_into_msb,
    input  logic             zero_in,
    output logic [7:0]       flags,
    output logic [7:0]       we
);
    logic is_sub, is_add, is_arith, is_logic, is_step;
    logic f_c, f_z, f_n, f_v, f_h;
    logic res_zero;
    logic [7:0] raw;

    assign is_add   = (op == OP_ADD) || (op == OP_ADC) || (op == OP_INC);
    assign is_sub   = (op == OP_SUB) || (op == OP_SBC) || (op == OP_NEG) || (op == OP_DEC);
    assign is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB)
                   || (op == OP_SBC) || (op == OP_NEG);
    assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    assign is_step  = (op == OP_INC) || (op == OP_DEC);
    assign res_zero = (res == '0);

    always_comb begin
        f_n = res[WIDTH-1];
        f_z = (op == OP_SBC) ? (res_zero & zero_in) : res_zero;
        f_v = 1'b0;
        f_c = 1'b0;
        f_h = 1'b0;
        if (is_add) begin
            f_c = c_out;
            f_h = c_half;
            f_v = c_out ^ c_into_msb;
        end else if (is_sub) begin
            f_c = ~c_out;
            f_h = ~c_half;
            f_v = c_out ^ c_into_msb;
        end else if (op == OP_COM) begin
            f_c = 1'b1;
        end
    end

    always_comb begin
        raw        = '0;
        raw[FB_C]  = f_c;
        raw[FB_Z]  = f_z;
        raw[FB_N]  = f_n;
        raw[FB_V]  = f_v;
        raw[FB_S]  = f_n ^ f_v;
        raw[FB_H]  = f_h;
        if (is_arith)           we = MASK_ARITH;
        else if (is_logic)      we = MASK_LOGIC;
        else if (is_step)       we = MASK_LOGIC;
        else if (op == OP_COM)  we = MASK_COM;
        else                    we = '0;
    end

    assign flags = raw & we;
endmodule

// File: rtl/alu8.sv
module alu8
    import alu8_pkg::*;
(
    input  logic [7:0] opnd_a,
    input  logic [7:0] opnd_b,
    input  logic       carry_in,
    input  logic       zero_in,
    input  logic [3:0] op_sel,
    output logic [7:0] result,
    output logic [7:0] flags_out,
    output logic [7:0] flag_we
);
    alu_op_e           op;
    logic [DATA_W-1:0] x_sel, y_sel, sum, logic_r;
    logic              inv_y, cin_sel, c_out, c_half, c_msb, use_adder;

    assign op = alu_op_e'(op_sel);

    always_comb begin
        x_sel     = opnd_a;
        y_sel     = opnd_b;
        inv_y     = 1'b0;
        cin_sel   = 1'b0;
        use_adder = 1'b1;
        case (op)
            OP_ADD: ;
            OP_ADC: cin_sel = carry_in;
            OP_SUB: begin inv_y = 1'b1; cin_sel = 1'b1; end
            OP_SBC: begin inv_y = 1'b1; cin_sel = ~carry_in; end
            OP_NEG: begin x_sel = '0; y_sel = opnd_a; inv_y = 1'b1; cin_sel = 1'b1; end
            OP_INC: begin y_sel = '0; cin_sel = 1'b1; end
            OP_DEC: begin y_sel = DATA_W'(1); inv_y = 1'b1; cin_sel = 1'b1; end
            default: use_adder = 1'b0;
        endcase
    end

    alu8_addsub #(.WIDTH(DATA_W), .HALF(NIB_W)) u_addsub (
        .x_in(x_sel), .y_in(y_sel), .invert_y(inv_y), .cin(cin_sel),
        .sum(sum), .c_out(c_out), .c_half(c_half), .c_into_msb(c_msb)
    );

    alu8_logic #(.WIDTH(DATA_W)) u_logic (
        .op(op), .a(opnd_a), .b(opnd_b), .r(logic_r)
    );

    assign result = use_adder ? sum : logic_r;

    alu8_flags #(.WIDTH(DATA_W)) u_flags (
        .op(op), .res(result), .c_out(c_out), .c_half(c_half),
        .c_into_msb(c_msb), .zero_in(zero_in), .flags(flags_out), .we(flag_we)
    );

    always_comb begin
        AST_SIGN_RULE: assert (!flag_we[FB_S] || (flags_out[FB_S] == (flags_out[FB_N] ^ flags_out[FB_V]))); // R8
        AST_LOGIC_V_ZERO: assert (!(op_sel inside {4'd4, 4'd5, 4'd6}) || !flags_out[FB_V]); // R4
        AST_COM_CARRY_SET: assert (op_sel != 4'd7 || (flags_out[FB_C] && result == ~opnd_a)); // R5
        AST_SBC_Z_STICKY: assert (op_sel != 4'd3 || zero_in || !flags_out[FB_Z]); // R3
        AST_UNUSED_NO_WRITE: assert (op_sel < 4'd11 || (flag_we == 8'h00 && result == opnd_a)); // R10
        AST_MASKED_ZERO: assert ((flags_out & ~flag_we) == 8'h00 && flag_we[7:6] == 2'b00); // R9
        AST_STEP_KEEPS_C: assert (!(op_sel inside {4'd9, 4'd10}) || !flag_we[FB_C]); // R7
    end
endmodule

// File: tb/sim_alu8.sv
module sim_alu8;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [7:0] opnd_a = '0, opnd_b = '0;
    logic       carry_in = 1'b0, zero_in = 1'b0;
    logic [3:0] op_sel = '0;
    logic [7:0] result, flags_out, flag_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic [7:0] flg;
        logic [7:0] we;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    alu8 u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in), .zero_in(zero_in),
        .op_sel(op_sel), .result(result), .flags_out(flags_out), .flag_we(flag_we)
    );

    function automatic exp_t model(input int a, input int b, input int c, input int z, input int op);
        exp_t e;
        int r, cf, hf, vf, zf, nf, d, dh;
        r = a; cf = 0; hf = 0; vf = 0;
        e.we = 8'h00;
        case (op)
            0, 1: begin
                if (op == 0) c = 0;
                r  = a + b + c;
                cf = (r > 255) ? 1 : 0;
                hf = (((a & 15) + (b & 15) + c) > 15) ? 1 : 0;
                r  = r & 255;
                vf = (((a >> 7) == (b >> 7)) && ((r >> 7) != (a >> 7))) ? 1 : 0;
                e.we = 8'h3F; e.tag = "R1/R2";
            end
            2, 3, 8: begin
                if (op == 2) c = 0;
                if (op == 8) begin b = a; a = 0; c = 0; end
                d  = a - b - c;
                dh = (a & 15) - (b & 15) - c;
                cf = (d < 0) ? 1 : 0;
                hf = (dh < 0) ? 1 : 0;
                r  = d & 255;
                vf = (((a >> 7) != (b >> 7)) && ((r >> 7) != (a >> 7))) ? 1 : 0;
                e.we = 8'h3F; e.tag = (op == 8) ? "R6" : (op == 3) ? "R3" : "R1/R2";
            end
            4, 5, 6: begin
                r = (op == 4) ? (a & b) : (op == 5) ? (a | b) : (a ^ b);
                e.we = 8'h1E; e.tag = "R4";
            end
            7: begin r = 255 - a; cf = 1; e.we = 8'h1F; e.tag = "R5"; end
            9: begin r = (a + 1) & 255; vf = (a == 127) ? 1 : 0; e.we = 8'h1E; e.tag = "R7"; end
            10: begin r = (a + 255) & 255; vf = (a == 128) ? 1 : 0; e.we = 8'h1E; e.tag = "R7"; end
            default: begin r = a; e.tag = "R10"; end
        endcase
        zf = (r == 0) ? 1 : 0;
        if (op == 3) zf = zf & z;
        nf = (r >> 7) & 1;
        e.res = 8'(r);
        e.flg = 8'((hf << 5) | ((nf ^ vf) << 4) | (vf << 3) | (nf << 2) | (zf << 1) | cf) & e.we;
        return e;
    endfunction

    task automatic drive(input int a, input int b, input int c, input int z, input int op);
        @(negedge clk);
        opnd_a = 8'(a); opnd_b = 8'(b); carry_in = c[0]; zero_in = z[0]; op_sel = 4'(op);
        sb.push_back(model(a, b, c, z, op));
    endtask

    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_cmp++;
            if (result !== e.res || flags_out !== e.flg || flag_we !== e.we) begin
                n_bad++;
                $display("FAIL %s: op=%0d a=%h b=%h c=%0b z=%0b got res=%h flg=%h we=%h exp res=%h flg=%h we=%h",
                         e.tag, op_sel, opnd_a, opnd_b, carry_in, zero_in,
                         result, flags_out, flag_we, e.res, e.flg, e.we);
            end
        end
    end

    initial begin
        // idle inputs: add of zeros gives Z only (R9 layout)
        drive(0, 0, 0, 0, 0);
        // R1 R2: carry, half carry, overflow
        drive(8'h0F, 8'h01, 0, 0, 0);
        drive(8'h7F, 8'h01, 0, 0, 0);
        drive(8'hFF, 8'h01, 0, 0, 0);
        drive(8'hFF, 8'hFF, 1, 0, 1);
        drive(8'h10, 8'h01, 0, 0, 2);
        drive(8'h80, 8'h01, 0, 0, 2);
        drive(8'h00, 8'h01, 0, 0, 2);
        // R3: sticky zero
        drive(8'h05, 8'h04, 1, 1, 3);
        drive(8'h05, 8'h04, 1, 0, 3);
        drive(8'h00, 8'h00, 1, 1, 3);
        // R4 logic
        drive(8'hF0, 8'h0F, 0, 0, 4);
        drive(8'h80, 8'h01, 1, 0, 5);
        drive(8'hAA, 8'hAA, 1, 0, 6);
        // R5 one's complement
        drive(8'hFF, 8'h00, 0, 0, 7);
        drive(8'h7F, 8'h00, 0, 0, 7);
        // R6 negate
        drive(8'h00, 8'h00, 0, 0, 8);
        drive(8'h80, 8'h00, 0, 0, 8);
        drive(8'h01, 8'h00, 0, 0, 8);
        // R7 inc/dec
        drive(8'h7F, 8'h00, 1, 0, 9);
        drive(8'hFF, 8'h00, 1, 0, 9);
        drive(8'h80, 8'h00, 1, 0, 10);
        drive(8'h00, 8'h00, 1, 0, 10);
        // R10 unused codes
        for (int k = 11; k < 16; k++) drive(8'h5A, 8'hC3, 1, 1, k);
        // random sweep, all codes (R8 sign rule on every item)
        for (int k = 0; k < 4000; k++)
            drive($urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 15));
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule